// File: doc/BRIEF.md
# PLL Step-Response Measurement Controller

This block measures how an integer-N phase-locked loop answers a phase disturbance that the block itself creates. It hands the feedback divider its divide value. During a run it changes that value by one for a single feedback period, then puts it back. This shifts the feedback phase by one VCO period. The block then follows the sign and size of the phase-error sample that the phase detector supplies once per reference cycle.

From that sample stream it records four results:
- the number of reference samples from the step to the first sample on the far side of zero (crossover);
- the largest error seen on that far side (peak overshoot);
- the signed mean error once the loop has come back inside a tolerance window (static error);
- a lock flag, which drops again on any later excursion.

A short crossover points to a wide loop bandwidth. A large overshoot points to strong jitter peaking. Both can be read from the results without a spectrum analyser.

A run is requested with a start pulse. The divisor, the step direction and the window are given on inputs. The results stay on the outputs until the next accepted start.

Top module: `pll_step_meter`

## Requirements
- R1: After reset `done`, `locked`, `bad_div` and `no_xover` are 0, `xover_cnt`, `max_os` and `static_err` are 0, and `div_out` equals `div_nom`.
- R2: A start while idle or done is rejected when `div_nom` < 8, or when `step_dir`=0 and `div_nom`=63. A rejected start sets `bad_div`, leaves `done` and all results unchanged and begins no run. An accepted start clears `bad_div`, `done`, `locked`, `no_xover` and all results.
- R3: After an accepted start, the step is applied only after 16 consecutive valid samples with `pe_mag` <= `win_lim`. Any sample with `pe_mag` > `win_lim` restarts that count.
- R4: While the step is applied, `div_out` is `div_nom`+1 when `step_dir`=0 and `div_nom`-1 when `step_dir`=1. The direction is latched at start. The step lasts from the cycle after pre-settling until the valid sample that arrives with `fb_wrap`=1. At every other time `div_out` equals `div_nom`.
- R5: A reversal is a valid sample with `pe_mag` != 0 and `pe_sign` != the latched direction. `pe_sign`=1 means a negative error. `xover_cnt` is the number of valid samples counted from the first sample of the step through the first reversal after the step has ended, inclusive. Samples with `pe_mag`=0 never count as a reversal.
- R6: If the 4095th counted sample is not a reversal, the run ends. At that point `done`=1, `no_xover`=1, `xover_cnt`=4095 (all ones), `locked`=0 and `static_err`=0.
- R7: `max_os` is the running maximum of `pe_mag` over reversed-side samples (same test as R5), taken from the crossover sample until the run completes.
- R8: After crossover, the first sample with `pe_mag` <= `win_lim` starts settling; this sample is not itself averaged. The run completes on 16 further consecutive in-window samples. An out-of-window sample restarts that count.
- R9: `static_err` is the floor of the sum of those 16 signed samples divided by 16, in 9-bit two's complement.
- R10: `locked` rises together with `done` on completion. It falls on any later valid sample with `pe_mag` > `win_lim` and does not rise again before the next run. `done` and all results hold until an accepted start.
- R11: A start that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, one-cycle pulse |
| step_dir | input | 1 | 0: step by +1, 1: step by -1 |
| div_nom | input | 6 | Nominal feedback divide value |
| win_lim | input | 8 | Settling window, largest in-window magnitude |
| pe_valid | input | 1 | Phase-error sample present this cycle |
| pe_sign | input | 1 | Sign of the sample, 1 = negative |
| pe_mag | input | 8 | Magnitude of the sample |
| fb_wrap | input | 1 | End of a feedback-divider period, qualified by pe_valid |
| div_out | output | 6 | Divide value for the feedback divider |
| done | output | 1 | Run finished, results valid |
| locked | output | 1 | Loop settled and still within the window |
| bad_div | output | 1 | Last start was rejected for its divisor |
| no_xover | output | 1 | Run ended without a reversal |
| xover_cnt | output | 12 | Samples from step to crossover |
| max_os | output | 8 | Largest overshoot magnitude |
| static_err | output | 9 | Signed mean settled error |

## Verification
A sequencer stuck in the wrong phase shows up first on `div_out`. It either fails to move by one on the cycle after the sixteenth settled sample, or it fails to return on the wrap sample. That is visible within a single cycle. A wrong sample counter or a missed reversal shows up as a shifted `xover_cnt`, or as a missing or early `done`, the moment the reversal is sent. Errors in the averaging path or the peak hold appear in `static_err` and `max_os` as soon as `done` rises. A sweep over both directions, several crossover lengths and two window widths makes any such deviation change at least one compared value.

// File: rtl/pll_step_meter_pkg.sv
package pll_step_meter_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_STEP,
        ST_XOVER,
        ST_OVS,
        ST_SETTLE,
        ST_DONE
    } meter_state_e;
endpackage

// File: rtl/psm_settle_mon.sv
// Counts consecutive in-window samples and accumulates their signed values.
module psm_settle_mon #(
    parameter int MAG_W      = 8,
    parameter int SETTLE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             smp_valid,
    input  logic             smp_sign,
    input  logic [MAG_W-1:0] smp_mag,
    input  logic [MAG_W-1:0] win,
    output logic             settled,
    output logic [MAG_W:0]   avg
);
    localparam int SH    = $clog2(SETTLE_LEN);
    localparam int RUN_W = $clog2(SETTLE_LEN + 1);
    localparam int SUM_W = MAG_W + 1 + SH;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [SUM_W-1:0] sum;
    } mon_t;

    mon_t mon_q, mon_d;
    logic             in_win;
    logic [SUM_W-1:0] mag_ext, smp_ext, sum_n;

    always_comb begin
        in_win  = (smp_mag <= win);
        mag_ext = SUM_W'(smp_mag);
        smp_ext = smp_sign ? (~mag_ext + 1'b1) : mag_ext;
        sum_n   = mon_q.sum + smp_ext;
        settled = en && smp_valid && in_win && (mon_q.run == RUN_W'(SETTLE_LEN - 1));
        avg     = sum_n[SH +: MAG_W + 1];
        mon_d   = mon_q;
        if (!en) begin
            mon_d.run = '0;
            mon_d.sum = '0;
        end else if (smp_valid) begin
            if (in_win) begin
                mon_d.run = mon_q.run + 1'b1;
                mon_d.sum = sum_n;
            end else begin
                mon_d.run = '0;
                mon_d.sum = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    // R8: the run length never passes the settle length
    assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.run <= RUN_W'(SETTLE_LEN));
    // R3: an out-of-window sample always restarts the count
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_valid && !in_win) |=> (mon_q.run == '0));
endmodule

// File: rtl/psm_peak_hold.sv
// Running maximum of reversed-side magnitudes.
module psm_peak_hold #(
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [MAG_W-1:0] val,
    output logic [MAG_W-1:0] peak
);
    typedef struct packed {
        logic [MAG_W-1:0] pk;
    } peak_t;

    peak_t pk_q, pk_d;

    always_comb begin
        pk_d = pk_q;
        if (clr)                      pk_d.pk = '0;
        else if (upd && val > pk_q.pk) pk_d.pk = val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign peak = pk_q.pk;

    // R7: the held peak never falls without a clear
    assert_peak_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (pk_q.pk >= $past(pk_q.pk)));
endmodule

// File: rtl/pll_step_meter.sv
module pll_step_meter
    import pll_step_meter_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int MAG_W       = 8,
    parameter int SETTLE_LEN  = 16,
    parameter int TIMEOUT     = 4096,
    parameter int DIV_RUN_MIN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      step_dir,
    input  logic [DIV_W-1:0]          div_nom,
    input  logic [MAG_W-1:0]          win_lim,
    input  logic                      pe_valid,
    input  logic                      pe_sign,
    input  logic [MAG_W-1:0]          pe_mag,
    input  logic                      fb_wrap,
    output logic [DIV_W-1:0]          div_out,
    output logic                      done,
    output logic                      locked,
    output logic                      bad_div,
    output logic                      no_xover,
    output logic [$clog2(TIMEOUT)-1:0] xover_cnt,
    output logic [MAG_W-1:0]          max_os,
    output logic [MAG_W:0]            static_err
);
    localparam int CNT_W = $clog2(TIMEOUT);
    localparam logic [DIV_W-1:0] DIV_TOP = '1;

    typedef struct packed {
        meter_state_e     st;
        logic             dir;
        logic             bad;
        logic             noxo;
        logic             lock;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] xo;
        logic [MAG_W:0]   stat;
    } meter_t;

    meter_t r_q, r_d;

    logic           out_win, opp, idle_like, div_ok, start_ok;
    logic           mon_en, settled, pk_clr, pk_upd;
    logic [MAG_W:0] avg;

    always_comb begin
        out_win   = (pe_mag > win_lim);
        opp       = (pe_sign != r_q.dir) && (pe_mag != '0);
        idle_like = (r_q.st == ST_IDLE) || (r_q.st == ST_DONE);
        div_ok    = (div_nom >= DIV_W'(DIV_RUN_MIN)) && !(!step_dir && div_nom == DIV_TOP);
        start_ok  = start && idle_like && div_ok;
        mon_en    = (r_q.st == ST_PRE) || (r_q.st == ST_SETTLE);
        pk_clr    = start_ok;
        pk_upd    = pe_valid && opp &&
                    ((r_q.st == ST_XOVER) || (r_q.st == ST_OVS) || (r_q.st == ST_SETTLE));
    end

    psm_settle_mon #(.MAG_W(MAG_W), .SETTLE_LEN(SETTLE_LEN)) settle_i (
        .clk(clk), .rst_n(rst_n), .en(mon_en), .smp_valid(pe_valid),
        .smp_sign(pe_sign), .smp_mag(pe_mag), .win(win_lim),
        .settled(settled), .avg(avg)
    );

    psm_peak_hold #(.MAG_W(MAG_W)) peak_i (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .upd(pk_upd),
        .val(pe_mag), .peak(max_os)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (r_q.st == ST_DONE && pe_valid && out_win) r_d.lock = 1'b0;
                if (start) begin
                    if (div_ok) begin
                        r_d.st   = ST_PRE;
                        r_d.dir  = step_dir;
                        r_d.bad  = 1'b0;
                        r_d.noxo = 1'b0;
                        r_d.lock = 1'b0;
                        r_d.cnt  = '0;
                        r_d.xo   = '0;
                        r_d.stat = '0;
                    end else begin
                        r_d.bad = 1'b1;
                    end
                end
            end
            ST_PRE: if (settled) r_d.st = ST_STEP;
            ST_STEP, ST_XOVER: begin
                if (pe_valid) begin
                    if (r_q.st == ST_XOVER && opp) begin
                        r_d.xo = r_q.cnt + 1'b1;
                        r_d.st = ST_OVS;
                    end else if (r_q.cnt == CNT_W'(TIMEOUT - 2)) begin
                        r_d.st   = ST_DONE;
                        r_d.noxo = 1'b1;
                        r_d.xo   = '1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.st == ST_STEP && fb_wrap) r_d.st = ST_XOVER;
                    end
                end
            end
            ST_OVS: if (pe_valid && !out_win) r_d.st = ST_SETTLE;
            ST_SETTLE: begin
                if (settled) begin
                    r_d.st   = ST_DONE;
                    r_d.lock = 1'b1;
                    r_d.stat = avg;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (r_q.st == ST_STEP) div_out = r_q.dir ? (div_nom - 1'b1) : (div_nom + 1'b1);
        else                   div_out = div_nom;
    end

    assign done       = (r_q.st == ST_DONE);
    assign locked     = r_q.lock;
    assign bad_div    = r_q.bad;
    assign no_xover   = r_q.noxo;
    assign xover_cnt  = r_q.xo;
    assign static_err = r_q.stat;

    // R4: the divide value moves by at most one from nominal
    assert_div_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_out != div_nom) |-> ((div_out == div_nom + 1'b1) || (div_out == div_nom - 1'b1)));
    // R10: lock only with a finished run
    assert_lock_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> done);
    // R6: a run without reversal saturates its count and is not locked
    assert_noxo_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        no_xover |-> ((xover_cnt == '1) && !locked));
    // R10: results hold while done and no start arrives
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(xover_cnt) && $stable(static_err) && $stable(max_os) && done));
    // R2: a start with a forbidden divisor flags an error and runs nothing
    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_like && !div_ok) |=> (bad_div && $stable(xover_cnt)));
endmodule

// File: tb/pll_step_meter_tb_top.sv
module pll_step_meter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, step_dir = 1'b0;
    logic [5:0]  div_nom = 6'd20;
    logic [7:0]  win_lim = 8'd3;
    logic        pe_valid = 1'b0, pe_sign = 1'b0, fb_wrap = 1'b0;
    logic [7:0]  pe_mag = '0;
    logic [5:0]  div_out;
    logic        done, locked, bad_div, no_xover;
    logic [11:0] xover_cnt;
    logic [7:0]  max_os;
    logic [8:0]  static_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_step_meter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .step_dir(step_dir),
        .div_nom(div_nom), .win_lim(win_lim), .pe_valid(pe_valid),
        .pe_sign(pe_sign), .pe_mag(pe_mag), .fb_wrap(fb_wrap),
        .div_out(div_out), .done(done), .locked(locked), .bad_div(bad_div),
        .no_xover(no_xover), .xover_cnt(xover_cnt), .max_os(max_os),
        .static_err(static_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic smp(input bit s, input int m, input bit w);
        @(negedge clk);
        pe_valid = 1'b1; pe_sign = s; pe_mag = 8'(m); fb_wrap = w;
        @(posedge clk); #1;
        pe_valid = 1'b0; fb_wrap = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // Pre-settle with one restart (R3), then the step (R4).
    task automatic pre_and_step(input int n, input bit dir, input int w);
        int stepped;
        for (int i = 0; i < 5; i++) smp(i[0], 0, 1'b0);
        smp(1'b0, w + 1, 1'b0);
        for (int i = 0; i < 15; i++) smp(i[0], w, 1'b0);
        chk("R3 no step before 16 settled", int'(div_out), n);
        smp(1'b1, 1, 1'b0);
        stepped = dir ? n - 1 : n + 1;
        chk("R4 stepped divisor", int'(div_out), stepped);
    endtask

    task automatic run_one(input int n, input bit dir, input int w, input int k);
        int mx, m, v, sum, exps;
        div_nom = 6'(n); step_dir = dir; win_lim = 8'(w);
        pulse_start();
        step_dir = ~dir;
        chk("R2 accepted start clears done", int'(done), 0);
        pre_and_step(n, dir, w);
        smp(dir, w + 4, 1'b0);
        chk("R4 step held before wrap", int'(div_out), dir ? n - 1 : n + 1);
        smp(dir, w + 2, 1'b1);
        chk("R4 divisor restored", int'(div_out), n);
        pulse_start();
        for (int i = 0; i < k - 3; i++) begin
            if (i == 0) smp(~dir, 0, 1'b0);
            else        smp(dir, (i * 5) % (w + 9), 1'b0);
        end
        chk("R5 no crossover yet", int'(done), 0);
        mx = w + 3 + (k % 4);
        smp(~dir, mx, 1'b0);
        for (int i = 0; i < 3; i++) begin
            m = w + 1 + (i * 3 + k) % 6;
            if (m > mx) mx = m;
            smp(~dir, m, 1'b0);
        end
        smp(dir, 0, 1'b0);
        for (int i = 0; i < 4; i++) smp(~dir, 1, 1'b0);
        smp(dir, w + 1, 1'b0);
        sum = 0;
        for (int i = 0; i < 16; i++) begin
            v = ((i * 7 + k + int'(dir)) % (2 * w + 1)) - w;
            sum += v;
            smp(v < 0, (v < 0) ? -v : v, 1'b0);
            if (i == 14) chk("R8 not done after 15", int'(done), 0);
        end
        exps = sum >>> 4;
        chk("R8 done after settle", int'(done), 1);
        chk("R5 crossover count", int'(xover_cnt), k);
        chk("R11 start ignored in run", int'(xover_cnt), k);
        chk("R7 max overshoot", int'(max_os), mx);
        chk("R9 static error", int'($signed(static_err)), exps);
        chk("R10 locked at done", int'(locked), 1);
        chk("R6 no_xover clear", int'(no_xover), 0);
        smp(dir, 0, 1'b0);
        chk("R10 lock kept in window", int'(locked), 1);
        smp(~dir, w + 1, 1'b0);
        chk("R10 lock dropped", int'(locked), 0);
        smp(dir, 0, 1'b0);
        chk("R10 no relock", int'(locked), 0);
        chk("R10 done held", int'(done), 1);
        chk("R10 count held", int'(xover_cnt), k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", int'(done), 0);
        chk("R1 locked", int'(locked), 0);
        chk("R1 bad_div", int'(bad_div), 0);
        chk("R1 no_xover", int'(no_xover), 0);
        chk("R1 xover", int'(xover_cnt), 0);
        chk("R1 max_os", int'(max_os), 0);
        chk("R1 static", int'(static_err), 0);
        chk("R1 div_out", int'(div_out), 20);

        for (int d = 0; d < 2; d++)
            for (int wi = 0; wi < 2; wi++)
                for (int ki = 0; ki < 3; ki++) begin
                    int kv, wv;
                    kv = (ki == 0) ? 3 : ((ki == 1) ? 6 : 20);
                    wv = (wi == 0) ? 2 : 7;
                    run_one(8 + (kv * 3 + wv * 5 + d * 11) % 55, d[0], wv, kv);
                end

        // R2 rejections while done
        div_nom = 6'd7; step_dir = 1'b1;
        pulse_start();
        chk("R2 N=7 rejected", int'(bad_div), 1);
        chk("R2 done kept", int'(done), 1);
        chk("R2 results kept", int'(xover_cnt), 20);
        div_nom = 6'd63; step_dir = 1'b0;
        pulse_start();
        chk("R2 N=63 up rejected", int'(bad_div), 1);
        chk("R2 div_out nominal", int'(div_out), 63);

        // R6 timeout with N=63 stepping down, also R2 boundary accept
        div_nom = 6'd63; step_dir = 1'b1; win_lim = 8'd3;
        pulse_start();
        chk("R2 accept clears bad_div", int'(bad_div), 0);
        for (int i = 0; i < 16; i++) smp(1'b0, 2, 1'b0);
        chk("R4 down step from 63", int'(div_out), 62);
        smp(1'b1, 10, 1'b1);
        for (int i = 0; i < 4093; i++) smp(1'b1, 9, 1'b0);
        chk("R6 not ended at 4094", int'(done), 0);
        smp(1'b1, 9, 1'b0);
        chk("R6 done on timeout", int'(done), 1);
        chk("R6 no_xover", int'(no_xover), 1);
        chk("R6 saturated count", int'(xover_cnt), 4095);
        chk("R6 not locked", int'(locked), 0);
        chk("R6 static zero", int'(static_err), 0);

        // R2 lower boundary accepted
        div_nom = 6'd8; step_dir = 1'b0;
        pulse_start();
        chk("R2 N=8 accepted", int'(done), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule